// File: doc/BRIEF.md
# Slow-to-Fast Pulse Synchronizer with Aligned Data

This block carries single-cycle event pulses from a slower source clock domain into a faster destination clock domain. The two clocks are asynchronous. The block produces exactly one destination-clock strobe for each source pulse. A data word that the source holds steady while its valid is high is sampled in the destination domain. That word is presented on the output so that it is valid in the same cycle as the strobe.

The valid input passes through a chain of destination-clock flip-flops. The first stage only feeds the next flop, which gives it a full cycle to settle out of metastability. The rising edge is taken from the last two stages. The data word travels through its own capture pipeline, which runs beside the valid chain. The output data register is loaded when the edge is found, so the data path is one register longer than the path to the edge detector.

By default the strobe is registered, which makes it glitch-free. A parameter can select a combinational strobe instead, which is one cycle earlier. The destination reset is asynchronous and active-low, and the block releases it internally in step with the destination clock.

Top module: `pulse_sync_s2f`

## Requirements
- R1: While `rst_n` is low, `dst_strobe_o` and `dst_data_o` are zero. The reset acts without waiting for a clock edge.
- R2: Every source pulse produces exactly one strobe. A source pulse is high for one source-clock cycle, which is longer than one destination period. Consecutive pulses are separated by at least one source cycle low, so that the destination clock sees the valid low on at least two rising edges.
- R3: The strobe is never high for two destination cycles in a row.
- R4: With the registered strobe (the default), the strobe is high in the cycle after the SYNC_STAGES-th destination rising edge that follows the source valid rising. With the defaults this is the third such edge.
- R5: In the strobe cycle, `dst_data_o` equals the word that was on `src_data_i` while the matching valid was high.
- R6: Between strobes, `dst_data_o` holds its last value. Changes on `src_data_i` while the valid is low do not affect it.
- R7: A source pulse that starts and ends while reset is asserted produces no strobe. No strobe appears until SYNC_STAGES cycles after the internal reset has been released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dst_clk | input | 1 | Destination (fast) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_valid_i | input | 1 | Single-cycle valid pulse from the source domain |
| src_data_i | input | DATA_W | Data word, held steady while the valid is high |
| dst_strobe_o | output | 1 | One-cycle strobe in the destination domain |
| dst_data_o | output | DATA_W | Data word aligned with the strobe, held between strobes |

## Verification
The assertions check four properties on every destination cycle:
- the strobe lasts one cycle;
- the strobe stays low while the oldest synchronizer stage stays high;
- the output data changes only at a load;
- the strobe stays quiet in the first cycles after the internal reset is released.

Only the bench scenarios can show the following:
- that each source pulse produces exactly one strobe;
- that the strobe arrives at the exact latency;
- that the data it carries matches;
- that a pulse swallowed by reset leaves no trace.

The bench tests these with random data and gaps, a minimum-spacing pulse pair, all-ones and all-zeros words, and a reset asserted while a pulse is in flight.

// File: rtl/psync_pkg.sv
`timescale 1ns/100ps
package psync_pkg;
  // smallest chain that leaves one settle-only stage in front of the edge pair
  localparam int unsigned MIN_STAGES = 3;

  // destination edges from source valid rise to strobe visible
  function automatic int unsigned strobe_latency(input int unsigned stages,
                                                 input bit reg_out);
    return reg_out ? stages : stages - 1;
  endfunction
endpackage

// File: rtl/psync_rst_release.sv
`timescale 1ns/100ps
module psync_rst_release (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] rel_q, rel_d;

  always_comb begin
    rel_d = {rel_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rel_q <= 2'b00;
    else         rel_q <= rel_d;
  end

  assign rst_n_o = rel_q[1];
endmodule

// File: rtl/psync_chain.sv
`timescale 1ns/100ps
module psync_chain #(
  parameter int unsigned STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic newer_o,
  output logic older_o
);
  logic [STAGES-1:0] stg_q, stg_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign stg_d[i] = din;
    end else begin : g_body
      assign stg_d[i] = stg_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign newer_o = stg_q[STAGES-2];
  assign older_o = stg_q[STAGES-1];
endmodule

// File: rtl/psync_edge.sv
`timescale 1ns/100ps
module psync_edge #(
  parameter bit REG_OUT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic newer_i,
  input  logic older_i,
  output logic rise_o,
  output logic strobe_o
);
  assign rise_o = newer_i & ~older_i;

  if (REG_OUT) begin : g_reg
    logic strb_q, strb_d;
    always_comb begin
      strb_d = rise_o;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strb_q <= 1'b0;
      else        strb_q <= strb_d;
    end
    assign strobe_o = strb_q;
  end else begin : g_comb
    assign strobe_o = rise_o;
  end

  // R3: the strobe is a single destination cycle wide
  assert_single_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);
endmodule

// File: rtl/psync_data_hold.sv
`timescale 1ns/100ps
module psync_data_hold #(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned STAGES  = 3,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              load_i,
  output logic [DATA_W-1:0] dout_o
);
  localparam int unsigned CAP = STAGES - 1;

  logic [DATA_W-1:0] cap_q [CAP];
  logic [DATA_W-1:0] cap_d [CAP];

  for (genvar i = 0; i < CAP; i++) begin : g_cap
    if (i == 0) begin : g_head
      assign cap_d[i] = din;
    end else begin : g_body
      assign cap_d[i] = cap_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cap_q[i] <= '0;
      else        cap_q[i] <= cap_d[i];
    end
  end

  if (REG_OUT) begin : g_reg
    logic [DATA_W-1:0] hold_q, hold_d;
    always_comb begin
      hold_d = hold_q;
      if (load_i) hold_d = cap_q[CAP-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= '0;
      else        hold_q <= hold_d;
    end
    assign dout_o = hold_q;

    // R6: the held word changes only after a detected edge
    assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout_o) |-> $past(load_i));
  end else begin : g_comb
    assign dout_o = cap_q[CAP-1];
  end
endmodule

// File: rtl/pulse_sync_s2f.sv
`timescale 1ns/100ps
module pulse_sync_s2f
  import psync_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 3,
  parameter bit          REG_STROBE  = 1'b1
) (
  input  logic              dst_clk,
  input  logic              rst_n,
  input  logic              src_valid_i,
  input  logic [DATA_W-1:0] src_data_i,
  output logic              dst_strobe_o,
  output logic [DATA_W-1:0] dst_data_o
);
  localparam int unsigned LAT   = strobe_latency(SYNC_STAGES, REG_STROBE);
  localparam int unsigned CNT_W = $clog2(LAT + 1);

  logic rst_int_n;
  logic stg_new, stg_old, rise;

  psync_rst_release u_rst (
    .clk     (dst_clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_int_n)
  );

  psync_chain #(.STAGES(SYNC_STAGES)) u_chain (
    .clk     (dst_clk),
    .rst_n   (rst_int_n),
    .din     (src_valid_i),
    .newer_o (stg_new),
    .older_o (stg_old)
  );

  psync_edge #(.REG_OUT(REG_STROBE)) u_edge (
    .clk      (dst_clk),
    .rst_n    (rst_int_n),
    .newer_i  (stg_new),
    .older_i  (stg_old),
    .rise_o   (rise),
    .strobe_o (dst_strobe_o)
  );

  psync_data_hold #(
    .DATA_W  (DATA_W),
    .STAGES  (SYNC_STAGES),
    .REG_OUT (REG_STROBE)
  ) u_data (
    .clk    (dst_clk),
    .rst_n  (rst_int_n),
    .din    (src_data_i),
    .load_i (rise),
    .dout_o (dst_data_o)
  );

  // cycles since internal reset release, saturating at LAT (guards R7)
  logic [CNT_W-1:0] quiet_q, quiet_d;
  always_comb begin
    quiet_d = quiet_q;
    if (quiet_q != CNT_W'(LAT)) quiet_d = quiet_q + 1'b1;
  end
  always_ff @(posedge dst_clk or negedge rst_int_n) begin
    if (!rst_int_n) quiet_q <= '0;
    else            quiet_q <= quiet_d;
  end

  // R7: no strobe can emerge before a pulse could have crossed the chain
  assert_quiet_after_reset_R7: assert property (@(posedge dst_clk) disable iff (!rst_int_n)
    (quiet_q < CNT_W'(LAT)) |-> !dst_strobe_o);

  // R2: a valid level already resident in the oldest stage yields no further strobe
  assert_one_per_level_R2: assert property (@(posedge dst_clk) disable iff (!rst_int_n)
    (stg_old && $past(stg_old)) |-> !dst_strobe_o);
endmodule

// File: tb/pulse_sync_s2f_tb_top.sv
`timescale 1ns/100ps
module pulse_sync_s2f_tb_top;
  localparam int DW  = 16;
  localparam int STG = 3;
  localparam int LAT = STG;   // registered strobe: R4

  logic          dst_clk, src_clk, rst_n;
  logic          src_valid;
  logic [DW-1:0] src_data;
  logic          strobe;
  logic [DW-1:0] dout;

  pulse_sync_s2f #(.DATA_W(DW), .SYNC_STAGES(STG), .REG_STROBE(1'b1)) dut_i (
    .dst_clk      (dst_clk),
    .rst_n        (rst_n),
    .src_valid_i  (src_valid),
    .src_data_i   (src_data),
    .dst_strobe_o (strobe),
    .dst_data_o   (dout)
  );

  int            cyc = 0;
  int            exp_cyc [256];
  logic [DW-1:0] exp_dat [256];
  int            wr = 0, rd = 0;
  logic [DW-1:0] last_dat = '0;
  int            n_run = 0, n_fail = 0;
  int            strobes_seen = 0;
  bit            prev_strobe = 0;
  bit            done = 0;

  initial begin
    dst_clk = 0;
    forever #2.5 dst_clk = ~dst_clk;
  end

  initial begin
    src_clk = 0;
    #1;
    forever begin
      src_clk = 1; #7;
      src_clk = 0; #7;
    end
  end

  always @(posedge dst_clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  // expected strobe cycle computed from the source edge time
  function automatic int due_cycle(input int now);
    return now + LAT;
  endfunction

  always @(negedge dst_clk) begin : monitor
    bit exp_s;
    exp_s = 0;
    if (!done) begin
      if (!rst_n) begin
        check(strobe == 1'b0, "R1 strobe in reset", 32'(strobe), 0);
        check(dout == '0, "R1 data in reset", 32'(dout), 0);
        rd = wr;
        last_dat = '0;
        prev_strobe = 0;
      end else begin
        while (rd < wr && exp_cyc[rd] < cyc) rd++;
        if (rd < wr && exp_cyc[rd] == cyc) exp_s = 1;
        check(strobe == exp_s, "R2/R4/R7 strobe timing", 32'(strobe), 32'(exp_s));
        if (exp_s) begin
          check(dout == exp_dat[rd], "R5 aligned data", 32'(dout), 32'(exp_dat[rd]));
          last_dat = exp_dat[rd];
          rd++;
        end else begin
          check(dout == last_dat, "R6 data held", 32'(dout), 32'(last_dat));
        end
        if (strobe) begin
          check(!prev_strobe, "R3 single-cycle strobe", 32'(prev_strobe), 0);
          strobes_seen++;
        end
        prev_strobe = strobe;
      end
    end
  end

  task automatic send(input logic [DW-1:0] d, input int gap);
    @(posedge src_clk);
    src_valid <= 1'b1;
    src_data  <= d;
    exp_cyc[wr] = due_cycle(cyc);
    exp_dat[wr] = d;
    wr++;
    @(posedge src_clk);
    src_valid <= 1'b0;
    src_data  <= DW'($urandom);     // R6: noise while valid is low
    repeat (gap) begin
      @(posedge src_clk);
      src_data <= DW'($urandom);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_n     = 1'b0;
    src_valid = 1'b0;
    src_data  = '0;
    repeat (6) @(negedge dst_clk);
    rst_n = 1'b1;
    repeat (10) @(negedge dst_clk);

    // directed corners: R5 extremes, R2 minimum spacing
    send('1, 2);
    send('0, 2);
    send(16'hA5C3, 0);
    send(16'h5A3C, 0);
    send(16'h0001, 3);

    // random data and gaps
    for (int i = 0; i < 60; i++) send(DW'($urandom), $urandom_range(0, 4));
    repeat (20) @(negedge dst_clk);

    // R7: pulse that lives entirely inside a reset window
    @(posedge src_clk);
    src_valid <= 1'b1;
    src_data  <= 16'hDEAD;
    #0.2 rst_n = 1'b0;
    @(posedge src_clk);
    src_valid <= 1'b0;
    #20;
    @(negedge dst_clk) rst_n = 1'b1;
    repeat (10) @(negedge dst_clk);

    // recovery after reset
    send(16'h1234, 3);
    repeat (20) @(negedge dst_clk);

    check(strobes_seen == wr, "R2 strobe count", 32'(strobes_seen), 32'(wr));
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule